// File: doc/BRIEF.md
# Address-Range Cache Maintenance Engine

This block takes a range of physical addresses and makes a cache write back, discard, or write back and then discard every line in that range. Software programs the range and the operation through a small word-addressed register port. The exclusive end address goes in first. The start address goes in last, and that write launches the walk. The engine then presents one line request at a time on a request/acknowledge port that faces the cache arrays. It moves to the next line only after the current request is acknowledged.

Two one-bit trigger registers start a walk over every line index of the cache, from index 0 up to the configured line count. These whole-cache walks use the same invalidate-mode bit and the same busy flag as range walks. Addresses may be wider than 32 bits. The upper bits live in separate upper-word registers, and the bits that are not implemented read back as zero. The line size is fixed at build time by a one-bit code: 0 gives 128-byte lines and 1 gives 64-byte lines.

Register map (`reg_addr`):
- 0 is the control register. It holds the region-op field in bits 11:9, the invalidate-mode bit in bit 6 and the read-only busy flag in bit 8.
- 1 and 2 hold the lower and upper start words.
- 3 and 4 hold the lower and upper end words.
- 5 is the whole-cache flush trigger (bit 0).
- 6 is the whole-cache invalidate trigger (bit 0).

Top module: `cme_region_engine`

## Requirements
- R1: After reset, every register reads 0, busy is 0 and `line_req` is low.
- R2: Writing register 1 while idle launches a walk over the line-aligned addresses from the start line up to, but not including, the end line. Lines are visited in ascending order with one request per line. `line_addr` and `line_op` stay held until `line_ack` is seen, and the next line follows at the address one line size higher.
- R3: Address bits below the line size are ignored in both start and end, the end being exclusive. Every `line_addr` has those low bits zero.
- R4: `line_op` is encoded as 01 for write back, 10 for discard and 11 for write back then discard. With the region-op field at 001, the op is 11 when the mode bit is 1 and 10 when it is 0. Field value 000, and any value other than 001, gives 01 whatever the mode bit.
- R5: Busy (control bit 8) reads 1 from the cycle after the launching write until the cycle after the last line is acknowledged. `line_req` is only high while busy.
- R6: If the aligned start line is at or above the aligned end line, no request is issued and busy is high for exactly one cycle.
- R7: While busy, writes to registers 1, 2, 3 and 4 and to the trigger registers are ignored. A rewrite of the end word reads back unchanged, and a rewrite of the start word issues no second walk.
- R8: Writing 1 to bit 0 of register 5 walks line indices 0 to CACHE_LINES-1 with op 01. Writing 1 to bit 0 of register 6 walks the same lines with the R4 invalidate encoding chosen by the mode bit. A 0 in bit 0 has no effect.
- R9: The upper words supply address bits ADDR_W-1:32 of start and end, and their bits 31 to ADDR_W-32 read back as 0.
- R10: With line-size code 0, lines are 128 bytes. With code 1, lines are 64 bytes, and the same programmed range is cut into 64-byte lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| line_req | output | 1 | A line operation is requested |
| line_addr | output | ADDR_W | Line-aligned address of the requested line |
| line_op | output | 2 | 01 write back, 10 discard, 11 write back then discard |
| line_ack | input | 1 | Cache accepts the current line request |

## Verification
The hardest situation to reach is a register write that arrives while a walk is in progress. It exists only while the cache side holds back its acknowledge. The stimulus slows the acknowledge to one in every four request cycles and issues the colliding end and start rewrites in that window. It then observes the end word read-back and the total number of line requests. The one-cycle busy pulse of an empty range is also narrow, so busy is sampled on each of the three cycles after launch.

// File: rtl/cme_pkg.sv
package cme_pkg;

  // register indices
  localparam logic [2:0] RIX_CTRL     = 3'd0;
  localparam logic [2:0] RIX_START_LO = 3'd1;
  localparam logic [2:0] RIX_START_HI = 3'd2;
  localparam logic [2:0] RIX_END_LO   = 3'd3;
  localparam logic [2:0] RIX_END_HI   = 3'd4;
  localparam logic [2:0] RIX_ALL_WB   = 3'd5;
  localparam logic [2:0] RIX_ALL_INV  = 3'd6;

  // control register bit positions
  localparam int CTL_FIELD_LSB = 9;
  localparam int CTL_BUSY_BIT  = 8;
  localparam int CTL_MODE_BIT  = 6;

  typedef enum logic [1:0] {
    LOP_NONE    = 2'b00,
    LOP_WB      = 2'b01,
    LOP_DISCARD = 2'b10,
    LOP_WB_INV  = 2'b11
  } line_op_e;

  // the region-op field value that selects the invalidate family
  function automatic logic field_is_inv(input logic [2:0] fld);
    return fld == 3'b001;
  endfunction

  // map (invalidate family, write-back-first mode) to a line operation
  function automatic line_op_e pick_op(input logic inv_fam, input logic wb_first);
    if (!inv_fam)      return LOP_WB;
    else if (wb_first) return LOP_WB_INV;
    else               return LOP_DISCARD;
  endfunction

  // line shift for the one-bit size code: 0 -> 128 B, 1 -> 64 B
  function automatic int line_shift(input int code);
    return (code == 0) ? 7 : 6;
  endfunction

endpackage

// File: rtl/cme_regs.sv
module cme_regs
  import cme_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int LSH         = 7,
  parameter int CACHE_LINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  output logic              launch,
  output logic [ADDR_W-LSH-1:0] first_ln,
  output logic [ADDR_W-LSH-1:0] limit_ln,
  output line_op_e          op
);
  localparam int UP_W = ADDR_W - 32;
  localparam int LN_W = ADDR_W - LSH;

  logic [2:0]      fld_q;
  logic            mode_q;
  logic [31:0]     start_lo_q, end_lo_q;
  logic [UP_W-1:0] start_hi_q, end_hi_q;

  // decoded write events
  logic wr_ctrl, wr_addr_ok, launch_rng, launch_all, all_is_inv;
  assign wr_ctrl    = we && (addr == RIX_CTRL);
  assign wr_addr_ok = we && !busy;
  assign launch_rng = wr_addr_ok && (addr == RIX_START_LO);
  assign launch_all = wr_addr_ok && wdata[0] &&
                      ((addr == RIX_ALL_WB) || (addr == RIX_ALL_INV));
  assign all_is_inv = (addr == RIX_ALL_INV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_q      <= '0;
      mode_q     <= 1'b0;
      start_lo_q <= '0;
      end_lo_q   <= '0;
      start_hi_q <= '0;
      end_hi_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        fld_q  <= wdata[CTL_FIELD_LSB +: 3];
        mode_q <= wdata[CTL_MODE_BIT];
      end
      if (wr_addr_ok) begin
        case (addr)
          RIX_START_LO: start_lo_q <= wdata;
          RIX_START_HI: start_hi_q <= wdata[UP_W-1:0];
          RIX_END_LO:   end_lo_q   <= wdata;
          RIX_END_HI:   end_hi_q   <= wdata[UP_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // full addresses; the start uses the word being written now
  logic [ADDR_W-1:0] start_full, end_full;
  assign start_full = {start_hi_q, wdata};
  assign end_full   = {end_hi_q, end_lo_q};

  assign launch   = launch_rng || launch_all;
  assign first_ln = launch_all ? '0 : start_full[ADDR_W-1:LSH];
  assign limit_ln = launch_all ? LN_W'(CACHE_LINES) : end_full[ADDR_W-1:LSH];
  assign op       = launch_all ? pick_op(all_is_inv, mode_q)
                               : pick_op(field_is_inv(fld_q), mode_q);

  always_comb begin
    rdata = '0;
    case (addr)
      RIX_CTRL: begin
        rdata[CTL_FIELD_LSB +: 3] = fld_q;
        rdata[CTL_BUSY_BIT]       = busy;
        rdata[CTL_MODE_BIT]       = mode_q;
      end
      RIX_START_LO: rdata = start_lo_q;
      RIX_START_HI: rdata = {{(32-UP_W){1'b0}}, start_hi_q};
      RIX_END_LO:   rdata = end_lo_q;
      RIX_END_HI:   rdata = {{(32-UP_W){1'b0}}, end_hi_q};
      default:      rdata = '0;
    endcase
  end

endmodule

// File: rtl/cme_walker.sv
module cme_walker
  import cme_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LSH    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  logic [ADDR_W-LSH-1:0] first_ln,
  input  logic [ADDR_W-LSH-1:0] limit_ln,
  input  line_op_e              op,
  input  logic                  ack,
  output logic                  busy,
  output logic                  req,
  output logic [ADDR_W-1:0]     req_addr,
  output line_op_e              req_op,
  output logic                  step,
  output logic                  finish
);
  localparam int LN_W = ADDR_W - LSH;

  logic            run_q;
  logic [LN_W-1:0] cur_q, lim_q;
  line_op_e        op_q;
  logic            have_line;

  assign have_line = run_q && (cur_q < lim_q);
  assign step      = have_line && ack;
  assign finish    = run_q && !have_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cur_q <= '0;
      lim_q <= '0;
      op_q  <= LOP_NONE;
    end else if (launch && !run_q) begin
      run_q <= 1'b1;
      cur_q <= first_ln;
      lim_q <= limit_ln;
      op_q  <= op;
    end else if (finish) begin
      run_q <= 1'b0;
    end else if (step) begin
      cur_q <= cur_q + 1'b1;
    end
  end

  assign busy     = run_q;
  assign req      = have_line;
  assign req_addr = {cur_q, {LSH{1'b0}}};
  assign req_op   = have_line ? op_q : LOP_NONE;

endmodule

// File: rtl/cme_region_engine.sv
module cme_region_engine
  import cme_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int LINE_CODE   = 0,
  parameter int CACHE_LINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              line_req,
  output logic [ADDR_W-1:0] line_addr,
  output logic [1:0]        line_op,
  input  logic              line_ack
);
  localparam int LSH  = line_shift(LINE_CODE);
  localparam int LN_W = ADDR_W - LSH;

  // internal events, named for the checker
  logic            busy;
  logic            launch;
  logic            line_step;
  logic            walk_done;
  logic [LN_W-1:0] first_ln, limit_ln;
  line_op_e        launch_op, walk_op;

  cme_regs #(
    .ADDR_W(ADDR_W), .LSH(LSH), .CACHE_LINES(CACHE_LINES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
    .launch(launch), .first_ln(first_ln), .limit_ln(limit_ln),
    .op(launch_op)
  );

  cme_walker #(
    .ADDR_W(ADDR_W), .LSH(LSH)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .first_ln(first_ln),
    .limit_ln(limit_ln), .op(launch_op), .ack(line_ack), .busy(busy),
    .req(line_req), .req_addr(line_addr), .req_op(walk_op),
    .step(line_step), .finish(walk_done)
  );

  assign line_op = walk_op;

endmodule

// File: rtl/cme_region_engine_chk.sv
module cme_region_engine_chk #(
  parameter int ADDR_W    = 40,
  parameter int LINE_CODE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              busy,
  input logic              line_req,
  input logic              line_ack,
  input logic [ADDR_W-1:0] line_addr,
  input logic [1:0]        line_op
);
  localparam int LSH  = (LINE_CODE == 0) ? 7 : 6;
  localparam int UP_W = ADDR_W - 32;
  localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << LSH;

  p_req_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> busy);

  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && !line_ack) |=> (line_req && $stable(line_addr) && $stable(line_op)));

  p_next_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && line_ack) |=> (!line_req || (line_addr == $past(line_addr) + LINE_BYTES)));

  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> (line_addr[LSH-1:0] == '0));

  p_op_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> (line_op != 2'b00));

  p_busy_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[8] == busy));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == 3'd2) || (reg_addr == 3'd4)) |-> (reg_rdata[31:UP_W] == '0));

  p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && ((reg_addr == 3'd1) || (reg_addr == 3'd5) ||
                                     (reg_addr == 3'd6))));

endmodule

bind cme_region_engine cme_region_engine_chk #(
  .ADDR_W(ADDR_W), .LINE_CODE(LINE_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .busy(busy), .line_req(line_req),
  .line_ack(line_ack), .line_addr(line_addr), .line_op(line_op)
);

// File: tb/tb_cme_region_engine.sv
module tb_cme_region_engine;

  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata, rdata64;
  logic          line_req, req64;
  logic [AW-1:0] line_addr, addr64;
  logic [1:0]    line_op, op64;
  logic          line_ack = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cme_region_engine #(.ADDR_W(AW), .LINE_CODE(0), .CACHE_LINES(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_req(line_req),
    .line_addr(line_addr), .line_op(line_op), .line_ack(line_ack)
  );

  cme_region_engine #(.ADDR_W(AW), .LINE_CODE(1), .CACHE_LINES(16)) dut64 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata64), .line_req(req64),
    .line_addr(addr64), .line_op(op64), .line_ack(req64)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // request log, written at negedges: a request with ack set there is taken at next posedge
  logic [AW-1:0] log_addr [0:31];
  logic [1:0]    log_op   [0:31];
  int            log_n = 0;
  int            gap = 0;
  int            gcnt = 0;
  int            n64 = 0;
  logic [AW-1:0] first64 = '0;

  always @(negedge clk) begin
    if (line_req) begin
      if (gcnt >= gap) begin
        line_ack = 1'b1;
        gcnt = 0;
        if (log_n < 32) begin
          log_addr[log_n] = line_addr;
          log_op[log_n]   = line_op;
        end
        log_n++;
      end else begin
        line_ack = 1'b0;
        gcnt++;
      end
    end else begin
      line_ack = 1'b0;
      gcnt = 0;
    end
    if (req64) begin
      if (n64 == 0) first64 = addr64;
      n64++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(3'd0, v);
      if (!v[8]) return;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [39:0] s;
    logic [39:0] e;
    logic [2:0]  fld;
    logic        im;
    logic [1:0]  gp;
    logic [7:0]  n;
    logic [1:0]  op;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{40'h00_0000_1000, 40'h00_0000_1200, 3'd0, 1'b0, 2'd0, 8'd4, 2'b01},
    '{40'h00_0000_1010, 40'h00_0000_1181, 3'd1, 1'b0, 2'd1, 8'd3, 2'b10},
    '{40'h00_0000_2000, 40'h00_0000_2100, 3'd1, 1'b1, 2'd2, 8'd2, 2'b11},
    '{40'h00_0000_0300, 40'h00_0000_0380, 3'd5, 1'b1, 2'd0, 8'd1, 2'b01},
    '{40'hA5_0000_0080, 40'hA5_0000_0200, 3'd0, 1'b0, 2'd1, 8'd3, 2'b01},
    '{40'h00_0000_0500, 40'h00_0000_0500, 3'd1, 1'b1, 2'd0, 8'd0, 2'b11},
    '{40'h00_0000_0580, 40'h00_0000_05FF, 3'd0, 1'b0, 2'd0, 8'd0, 2'b01},
    '{40'h00_0000_0900, 40'h00_0000_0400, 3'd0, 1'b0, 2'd0, 8'd0, 2'b01},
    '{40'h00_0000_0000, 40'h00_0000_0080, 3'd0, 1'b1, 2'd0, 8'd1, 2'b01}
  };

  task automatic check_walk(input string req, input int n, input logic [AW-1:0] first,
                            input logic [1:0] op);
    chk(log_n == n, req, 64'(log_n), 64'(n));
    for (int i = 0; i < n && i < 32 && i < log_n; i++) begin
      chk(log_addr[i] == first + AW'(i * 128), req, 64'(log_addr[i]),
          64'(first + AW'(i * 128)));
      chk(log_op[i] == op, req, 64'(log_op[i]), 64'(op));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk(v == 32'h0, "R1 reg reset", 64'(v), 64'h0);
    end
    chk(line_req == 1'b0, "R1 no request", 64'(line_req), 64'h0);

    // table of range walks: R2 R3 R4 R6 R9
    for (int k = 0; k < 9; k++) begin
      vec_t t;
      t = VECS[k];
      wr(3'd0, (32'(t.fld) << 9) | (32'(t.im) << 6));
      wr(3'd4, 32'(t.e[39:32]));
      wr(3'd3, t.e[31:0]);
      wr(3'd2, 32'(t.s[39:32]));
      gap = int'(t.gp);
      log_n = 0;
      wr(3'd1, t.s[31:0]);
      wait_idle();
      repeat (2) @(negedge clk);
      check_walk("R2 R3 R4 R6 R9 range walk", int'(t.n),
                 {t.s[AW-1:7], 7'b0}, t.op);
    end
    gap = 0;

    // R5 busy timing, one line
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    wr(3'd3, 32'h680);
    wr(3'd1, 32'h600);
    rd(3'd0, v); chk(v[8] == 1'b1, "R5 busy after launch", 64'(v[8]), 64'h1);
    @(negedge clk);
    rd(3'd0, v); chk(v[8] == 1'b1, "R5 busy during last ack", 64'(v[8]), 64'h1);
    @(negedge clk);
    rd(3'd0, v); chk(v[8] == 1'b0, "R5 busy clear", 64'(v[8]), 64'h0);

    // R6 empty range: busy exactly one cycle, no request
    log_n = 0;
    wr(3'd3, 32'h700);
    wr(3'd1, 32'h77F);
    rd(3'd0, v); chk(v[8] == 1'b1, "R6 busy one cycle", 64'(v[8]), 64'h1);
    @(negedge clk);
    rd(3'd0, v); chk(v[8] == 1'b0, "R6 busy gone", 64'(v[8]), 64'h0);
    chk(log_n == 0, "R6 no requests", 64'(log_n), 64'h0);

    // R7 writes while busy are ignored
    gap = 3;
    log_n = 0;
    wr(3'd3, 32'h4200);
    wr(3'd1, 32'h4000);
    wr(3'd3, 32'hFFFF00);
    rd(3'd3, v); chk(v == 32'h4200, "R7 end word kept", 64'(v), 64'h4200);
    wr(3'd1, 32'h8000);
    wr(3'd5, 32'h1);
    wait_idle();
    repeat (2) @(negedge clk);
    check_walk("R7 single walk", 4, 40'h4000, 2'b01);
    rd(3'd1, v); chk(v == 32'h4000, "R7 start word kept", 64'(v), 64'h4000);
    gap = 0;

    // R8 whole-cache triggers
    wr(3'd0, 32'h0);
    log_n = 0;
    wr(3'd5, 32'h1);
    wait_idle(); repeat (2) @(negedge clk);
    check_walk("R8 flush all", 16, 40'h0, 2'b01);
    wr(3'd0, 32'h40);
    log_n = 0;
    wr(3'd6, 32'h1);
    wait_idle(); repeat (2) @(negedge clk);
    check_walk("R8 invalidate all wb", 16, 40'h0, 2'b11);
    wr(3'd0, 32'h0);
    log_n = 0;
    wr(3'd6, 32'h1);
    wait_idle(); repeat (2) @(negedge clk);
    check_walk("R8 invalidate all discard", 16, 40'h0, 2'b10);
    log_n = 0;
    wr(3'd5, 32'h0);
    rd(3'd0, v); chk(v[8] == 1'b0, "R8 zero trigger inert", 64'(v[8]), 64'h0);
    chk(log_n == 0, "R8 zero trigger no lines", 64'(log_n), 64'h0);

    // R9 upper word read-back width
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk(v == 32'hFF, "R9 end upper", 64'(v), 64'hFF);
    wr(3'd2, 32'h1234_5678);
    rd(3'd2, v); chk(v == 32'h78, "R9 start upper", 64'(v), 64'h78);

    // R10 line size code: same range on 128 B and 64 B lines
    repeat (80) @(negedge clk);
    wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    wr(3'd3, 32'h140);
    log_n = 0; n64 = 0;
    wr(3'd1, 32'h40);
    wait_idle(); repeat (10) @(negedge clk);
    check_walk("R10 128B lines", 2, 40'h0, 2'b01);
    chk(n64 == 4, "R10 64B line count", 64'(n64), 64'h4);
    chk(first64 == 40'h40, "R10 64B first line", 64'(first64), 64'h40);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule